// File: doc/BRIEF.md
# External Audio DAC Serial Output

This block drives a stand-alone stereo audio DAC. From a system clock and a tick enable at twice the master clock rate, it builds three clocks. The master clock runs at 384 times the sample rate. The bit clock runs at 32 times the sample rate. The word clock runs at the sample rate. The block serialises one 16-bit left sample and one 16-bit right sample per frame. The sample source sees a one-cycle take strobe at the end of every frame and is expected to offer the next stereo pair at that moment.

A small command port sets four things: the mute level, the de-emphasis level, the DAC path (internal or external) and a format byte. The format byte selects standard-aligned or left-justified framing and inverts the word clock and the bit clock. Format and path changes wait for the next frame boundary, so a frame is never emitted with mixed settings. Mute acts at once.

Top module: `audio_dac_serializer`

## Requirements
- R1: While the external path is active, `dac_mclk` toggles on every tick, so one master-clock period is two ticks and a frame holds 384 master-clock periods (768 ticks).
- R2: A bit period is 24 ticks (12 master-clock periods) and a frame holds 32 of them. With bit-clock inversion off, `dac_bck` is low for the first 12 ticks of each bit period and high for the last 12.
- R3: `dac_lrck` changes only at the start of bit period 0 or bit period 16. In left-justified mode it is high during bit periods 0..15, which carry the left channel; in standard-aligned mode it is low during them (before any inversion).
- R4: In left-justified mode, bit period b carries L[15-b] for b<16 and R[31-b] for b>=16, MSB first. `dac_sdata` changes only at the start of a bit period, which is the edge opposite the one the DAC samples on.
- R5: In standard-aligned mode the data lags the word clock by one bit period. Bit period 0 carries bit 0 of the previous frame's right sample, periods 1..16 carry L[16-b], and periods 17..31 carry R[32-b].
- R6: Command op 7 loads the format from `cmd_arg`. Bit 2 selects standard-aligned mode, bit 1 inverts `dac_lrck` and bit 0 inverts `dac_bck`. Bits 7..3 are ignored.
- R7: `dac_mute_n` is low after reset. Op 1 drives it low and op 2 drives it high. In the cycle after it goes low, `dac_sdata` is 0 and stays 0 while muted, and the clocks keep running.
- R8: Op 3 drives `dac_deemph` high and op 4 drives it low. Op 0 does nothing.
- R9: The internal path is selected after reset. Op 6 selects the external path and op 5 selects the internal path. While the internal path is active, `dac_mclk`, `dac_bck`, `dac_lrck` and `dac_sdata` are all low. Path and format changes take effect at the next frame start.
- R10: `pcm_take` is high for exactly one cycle: the tick that ends a frame. The pair on `pcm_left`/`pcm_right` is latched for the next frame if `pcm_valid` is high in that cycle; otherwise the next frame carries zeros.
- R11: In a cycle with `tick` low, no serial output or frame position changes.
- R12: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Enable at twice the master-clock rate |
| pcm_valid | input | 1 | A stereo pair is offered |
| pcm_left | input | 16 | Left sample |
| pcm_right | input | 16 | Right sample |
| pcm_take | output | 1 | Frame boundary; pair is taken this cycle |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0..7) |
| cmd_arg | input | 8 | Format byte for op 7 |
| dac_mclk | output | 1 | Master clock, 384x sample rate |
| dac_bck | output | 1 | Bit clock, 32x sample rate |
| dac_lrck | output | 1 | Word clock, sample rate |
| dac_sdata | output | 1 | Serial data |
| dac_deemph | output | 1 | De-emphasis, active high |
| dac_mute_n | output | 1 | Mute, active low |

## Verification
The assertions assume that every input changes synchronously to `clk`, that at most one command arrives per cycle, and that `tick` may have arbitrary gaps but is never wider than one cycle per step. The bench drives all inputs on the falling edge. Each cycle it issues at most one command and randomises the tick gaps and sample availability. Each format, path and mute change therefore lands at an arbitrary point in a frame, and the frame-boundary deferral is exercised from every phase.

// File: rtl/dac_ser_pkg.sv
package dac_ser_pkg;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_MUTE_ON    = 3'd1,
        OP_MUTE_OFF   = 3'd2,
        OP_DEEMPH_ON  = 3'd3,
        OP_DEEMPH_OFF = 3'd4,
        OP_PATH_INT   = 3'd5,
        OP_PATH_EXT   = 3'd6,
        OP_SET_FMT    = 3'd7
    } dac_op_e;

    // Packed order is the format byte bit order: [2] aligned, [1] lrck inv, [0] bck inv
    typedef struct packed {
        logic i2s;
        logic lr_inv;
        logic bck_inv;
    } dac_fmt_t;

endpackage

// File: rtl/dac_cmd_regs.sv
module dac_cmd_regs
    import dac_ser_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic [7:0] cmd_arg,
    output logic       mute_n,
    output logic       deemph,
    output logic       ext_pend,
    output dac_fmt_t   fmt_pend
);

    typedef struct packed {
        logic     mute_n;
        logic     deemph;
        logic     ext;
        dac_fmt_t fmt;
    } regs_t;

    regs_t reg_d, reg_q;
    logic  unused_arg_hi;

    assign unused_arg_hi = ^cmd_arg[7:3];

    always_comb begin
        reg_d = reg_q;
        if (cmd_valid) begin
            case (dac_op_e'(cmd_op))
                OP_MUTE_ON:    reg_d.mute_n = 1'b0;
                OP_MUTE_OFF:   reg_d.mute_n = 1'b1;
                OP_DEEMPH_ON:  reg_d.deemph = 1'b1;
                OP_DEEMPH_OFF: reg_d.deemph = 1'b0;
                OP_PATH_INT:   reg_d.ext    = 1'b0;
                OP_PATH_EXT:   reg_d.ext    = 1'b1;
                OP_SET_FMT:    reg_d.fmt    = dac_fmt_t'(cmd_arg[2:0]);
                default:       ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign mute_n   = reg_q.mute_n;
    assign deemph   = reg_q.deemph;
    assign ext_pend = reg_q.ext;
    assign fmt_pend = reg_q.fmt;

    a_r8_deemph_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_DEEMPH_ON) |=> deemph);

endmodule

// File: rtl/dac_frame_timer.sv
module dac_frame_timer #(
    parameter int SUB_N = 24,
    parameter int SUB_W = 5,
    parameter int BIT_N = 32,
    parameter int BIT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [SUB_W-1:0] sub_o,
    output logic [BIT_W-1:0] bit_o,
    output logic [SUB_W-1:0] nxt_sub,
    output logic [BIT_W-1:0] nxt_bit,
    output logic             wrap
);

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [BIT_W-1:0] bitn;
    } pos_t;

    pos_t pos_d, pos_q;
    logic last_sub, last_bit;

    always_comb begin
        last_sub = (pos_q.sub  == SUB_W'(SUB_N - 1));
        last_bit = (pos_q.bitn == BIT_W'(BIT_N - 1));
        pos_d    = pos_q;
        if (adv) begin
            if (last_sub) begin
                pos_d.sub  = '0;
                pos_d.bitn = last_bit ? '0 : pos_q.bitn + 1'b1;
            end else begin
                pos_d.sub  = pos_q.sub + 1'b1;
            end
        end
        wrap = adv && last_sub && last_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign sub_o   = pos_q.sub;
    assign bit_o   = pos_q.bitn;
    assign nxt_sub = pos_d.sub;
    assign nxt_bit = pos_d.bitn;

    a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(sub_o) && $stable(bit_o)));

endmodule

// File: rtl/dac_serializer.sv
module dac_serializer
    import dac_ser_pkg::*;
#(
    parameter int PCM_W = 16,
    parameter int SUB_N = 24,
    parameter int SUB_W = 5,
    parameter int BIT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             wrap,
    input  logic [SUB_W-1:0] nxt_sub,
    input  logic [BIT_W-1:0] nxt_bit,
    input  logic             pcm_valid,
    input  logic [PCM_W-1:0] pcm_left,
    input  logic [PCM_W-1:0] pcm_right,
    input  dac_fmt_t         fmt_pend,
    input  logic             ext_pend,
    input  logic             mute_n,
    output logic             pcm_take,
    output logic             mclk_o,
    output logic             bck_o,
    output logic             lrck_o,
    output logic             sdata_o
);

    localparam int WORD_W   = 2 * PCM_W;
    localparam int SUB_HALF = SUB_N / 2;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        dac_fmt_t          fmt;
        logic              ext;
        logic              mclk;
        logic              bck;
        logic              lrck;
        logic              sd;
    } ser_t;

    ser_t              ser_d, ser_q;
    dac_fmt_t          fmt_use;
    logic              ext_use, left_half, lr_raw, lj_bit, al_bit;
    logic [WORD_W-1:0] new_word, src;
    logic [BIT_W-1:0]  lj_idx, al_idx;

    always_comb begin
        ser_d     = ser_q;
        fmt_use   = wrap ? fmt_pend : ser_q.fmt;
        ext_use   = wrap ? ext_pend : ser_q.ext;
        new_word  = pcm_valid ? {pcm_left, pcm_right} : '0;
        src       = wrap ? new_word : ser_q.word;
        left_half = (nxt_bit < BIT_W'(PCM_W));
        lr_raw    = fmt_use.i2s ? ~left_half : left_half;
        lj_idx    = BIT_W'(WORD_W - 1 - int'(nxt_bit));
        al_idx    = BIT_W'(WORD_W - int'(nxt_bit));
        lj_bit    = src[lj_idx];
        // bit period 0 of an aligned frame still carries the old right LSB
        al_bit    = (nxt_bit == '0) ? ser_q.word[0] : src[al_idx];
        if (adv) begin
            ser_d.fmt  = fmt_use;
            ser_d.ext  = ext_use;
            ser_d.mclk = ext_use & nxt_sub[0];
            ser_d.bck  = ext_use & ((nxt_sub >= SUB_W'(SUB_HALF)) ^ fmt_use.bck_inv);
            ser_d.lrck = ext_use & (lr_raw ^ fmt_use.lr_inv);
            if (nxt_sub == '0)
                ser_d.sd = ext_use & (fmt_use.i2s ? al_bit : lj_bit);
            if (wrap)
                ser_d.word = new_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ser_q <= '0;
        else        ser_q <= ser_d;
    end

    assign pcm_take = wrap;
    assign mclk_o   = ser_q.mclk;
    assign bck_o    = ser_q.bck;
    assign lrck_o   = ser_q.lrck;
    assign sdata_o  = ser_q.sd & mute_n;

    a_r1_mclk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ser_q.ext && !wrap) |=> (mclk_o != $past(mclk_o)));

    a_r11_clocks_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(mclk_o) && $stable(bck_o) && $stable(lrck_o)));

    a_r9_internal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_q.ext |-> !(mclk_o || bck_o || lrck_o || sdata_o));

endmodule

// File: rtl/audio_dac_serializer.sv
module audio_dac_serializer
    import dac_ser_pkg::*;
#(
    parameter int PCM_W      = 16,
    parameter int MCLK_RATIO = 384,
    parameter int BCK_RATIO  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pcm_valid,
    input  logic [PCM_W-1:0] pcm_left,
    input  logic [PCM_W-1:0] pcm_right,
    output logic             pcm_take,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [7:0]       cmd_arg,
    output logic             dac_mclk,
    output logic             dac_bck,
    output logic             dac_lrck,
    output logic             dac_sdata,
    output logic             dac_deemph,
    output logic             dac_mute_n
);

    localparam int SUB_N = 2 * MCLK_RATIO / BCK_RATIO;
    localparam int SUB_W = $clog2(SUB_N);
    localparam int BIT_N = BCK_RATIO;
    localparam int BIT_W = $clog2(BIT_N);

    logic             mute_n, ext_pend, wrap;
    dac_fmt_t         fmt_pend;
    logic [SUB_W-1:0] t_sub, n_sub;
    logic [BIT_W-1:0] t_bit, n_bit;

    dac_cmd_regs u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_arg  (cmd_arg),
        .mute_n   (mute_n),
        .deemph   (dac_deemph),
        .ext_pend (ext_pend),
        .fmt_pend (fmt_pend)
    );

    dac_frame_timer #(
        .SUB_N(SUB_N), .SUB_W(SUB_W), .BIT_N(BIT_N), .BIT_W(BIT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (tick),
        .sub_o  (t_sub),
        .bit_o  (t_bit),
        .nxt_sub(n_sub),
        .nxt_bit(n_bit),
        .wrap   (wrap)
    );

    dac_serializer #(
        .PCM_W(PCM_W), .SUB_N(SUB_N), .SUB_W(SUB_W), .BIT_W(BIT_W)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (tick),
        .wrap     (wrap),
        .nxt_sub  (n_sub),
        .nxt_bit  (n_bit),
        .pcm_valid(pcm_valid),
        .pcm_left (pcm_left),
        .pcm_right(pcm_right),
        .fmt_pend (fmt_pend),
        .ext_pend (ext_pend),
        .mute_n   (mute_n),
        .pcm_take (pcm_take),
        .mclk_o   (dac_mclk),
        .bck_o    (dac_bck),
        .lrck_o   (dac_lrck),
        .sdata_o  (dac_sdata)
    );

    assign dac_mute_n = mute_n;

    a_r10_take_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_take |=> (t_sub == '0 && t_bit == '0));

    a_r3_lrck_edge_place: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_lrck != $past(dac_lrck)) |-> (t_sub == '0 && (t_bit == '0 || t_bit == BIT_W'(PCM_W))));

    a_r7_mute_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_MUTE_ON) |=> (!dac_mute_n && !dac_sdata));

endmodule

// File: tb/audio_dac_serializer_bench.sv
module audio_dac_serializer_bench;

    logic        clk = 1'b0;
    logic        rst_n, tick, pcm_valid, cmd_valid;
    logic [15:0] pcm_left, pcm_right;
    logic [2:0]  cmd_op;
    logic [7:0]  cmd_arg;
    logic        pcm_take, dac_mclk, dac_bck, dac_lrck, dac_sdata, dac_deemph, dac_mute_n;

    always #4 clk = ~clk;

    audio_dac_serializer u_audio_dac_serializer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pcm_valid(pcm_valid),
        .pcm_left(pcm_left), .pcm_right(pcm_right), .pcm_take(pcm_take),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .dac_mclk(dac_mclk), .dac_bck(dac_bck), .dac_lrck(dac_lrck),
        .dac_sdata(dac_sdata), .dac_deemph(dac_deemph), .dac_mute_n(dac_mute_n)
    );

    int n_chk = 0, n_bad = 0;
    int tick_pct = 100, valid_pct = 100, cmd_rate = 0;
    bit done = 0;

    // reference state, built from the requirements
    int          p = 0;
    logic [15:0] cur_l = 0, cur_r = 0, prev_r = 0;
    logic [2:0]  fmt_act = 0, fmt_pend = 0;
    logic        ext_act = 0, ext_pend = 0, mute_n_m = 0, deemph_m = 0;

    task automatic chk(input string name, input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b (pos %0d fmt %0d)", req, name, act, exp, p, fmt_act);
        end
    endtask

    function automatic logic exp_bit();
        int b = p / 24;
        if (!fmt_act[2]) return (b < 16) ? cur_l[15-b] : cur_r[31-b];   // R4
        if (b == 0) return prev_r[0];                                   // R5
        return (b <= 16) ? cur_l[16-b] : cur_r[32-b];
    endfunction

    task automatic compare_outputs();
        int   sub = p % 24;
        logic left = (p / 24) < 16;
        string dtag;
        chk("mclk", "R1", dac_mclk, ext_act & ((p % 2) == 1));
        chk("bck", fmt_act[0] ? "R6" : "R2", dac_bck, ext_act & ((sub >= 12) ^ fmt_act[0]));
        chk("lrck", "R3", dac_lrck, ext_act & ((fmt_act[2] ? !left : left) ^ fmt_act[1]));
        dtag = !ext_act ? "R9" : (!mute_n_m ? "R7" : (fmt_act[2] ? "R5" : "R4"));
        chk("sdata", dtag, dac_sdata, ext_act & mute_n_m & exp_bit());
        chk("mute_n", "R7", dac_mute_n, mute_n_m);
        chk("deemph", "R8", dac_deemph, deemph_m);
    endtask

    task automatic step(input logic cv, input logic [2:0] op, input logic [7:0] arg);
        tick      = ($urandom % 100) < tick_pct;
        pcm_valid = ($urandom % 100) < valid_pct;
        pcm_left  = 16'($urandom);
        pcm_right = 16'($urandom);
        cmd_valid = cv;
        cmd_op    = op;
        cmd_arg   = arg;
        #1;
        chk("pcm_take", "R10", pcm_take, tick && p == 767);
        @(posedge clk);
        if (tick) begin
            p = (p + 1) % 768;
            if (p == 0) begin
                prev_r  = cur_r;
                cur_l   = pcm_valid ? pcm_left  : 16'h0;
                cur_r   = pcm_valid ? pcm_right : 16'h0;
                fmt_act = fmt_pend;
                ext_act = ext_pend;
            end
        end
        if (cv) begin
            case (op)
                3'd1: mute_n_m = 1'b0;
                3'd2: mute_n_m = 1'b1;
                3'd3: deemph_m = 1'b1;
                3'd4: deemph_m = 1'b0;
                3'd5: ext_pend = 1'b0;
                3'd6: ext_pend = 1'b1;
                3'd7: fmt_pend = arg[2:0];
                default: ;
            endcase
        end
        @(negedge clk);
        compare_outputs();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            logic cv = (cmd_rate != 0) && (($urandom % cmd_rate) == 0);
            step(cv, 3'($urandom % 8), 8'($urandom));
        end
    endtask

    initial begin
        logic b0, l0, m0;
        void'($urandom(32'd20240611));
        rst_n = 0; tick = 0; pcm_valid = 0; pcm_left = 0; pcm_right = 0;
        cmd_valid = 0; cmd_op = 0; cmd_arg = 0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("mclk", "R12", dac_mclk, 1'b0);
        chk("bck", "R12", dac_bck, 1'b0);
        chk("lrck", "R12", dac_lrck, 1'b0);
        chk("sdata", "R12", dac_sdata, 1'b0);
        chk("mute_n", "R12", dac_mute_n, 1'b0);
        chk("deemph", "R12", dac_deemph, 1'b0);
        chk("pcm_take", "R12", pcm_take, 1'b0);
        rst_n = 1;
        @(negedge clk);

        // R9: internal path after reset keeps the pins low
        run(800);
        step(1'b1, 3'd2, 8'h00);   // R7 mute off
        step(1'b1, 3'd6, 8'h00);   // R9 external, deferred to frame start
        step(1'b1, 3'd3, 8'h00);   // R8 de-emphasis on
        step(1'b1, 3'd0, 8'h00);   // R8 no-op
        tick_pct = 90;
        // R6: each format, upper bits set to show they are ignored
        for (int f = 0; f < 8; f++) begin
            step(1'b1, 3'd7, 8'hF8 | 8'(f));
            run(1700);
        end
        // R10: no sample offered, zeros go out
        valid_pct = 0;
        run(900);
        valid_pct = 100;
        // R7: mute mid-frame, clocks keep running
        run(300);
        step(1'b1, 3'd1, 8'h00);
        run(400);
        step(1'b1, 3'd2, 8'h00);
        step(1'b1, 3'd4, 8'h00);   // R8 de-emphasis off
        // R11: no ticks, nothing moves
        tick_pct = 0;
        b0 = dac_bck; l0 = dac_lrck; m0 = dac_mclk;
        run(40);
        chk("bck_hold", "R11", dac_bck, b0);
        chk("lrck_hold", "R11", dac_lrck, l0);
        chk("mclk_hold", "R11", dac_mclk, m0);
        tick_pct = 90;
        // R9: back to internal at the next frame start
        step(1'b1, 3'd5, 8'h00);
        run(1000);
        step(1'b1, 3'd6, 8'h00);
        // random phase: commands land anywhere in a frame
        valid_pct = 80;
        cmd_rate = 150;
        run(20000);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule